// File: doc/BRIEF.md
# Multiplexed Bus Byte-Lane Steering

This block places the address, the byte enables and the write data of an external-bus access onto a 32-bit shared address/data bus. It also steers the read data that comes back from that bus into a right-justified word. The bus has two phases. While the address-latch-enable (ALE) phase is active, the bus carries the address and the inverted byte enables. In the data phase that follows, the data bytes sit on lanes chosen by the device width (8, 16 or 32 bits) and by the byte order. A direct mode serves parts that have no multiplexing: one data byte and a 24-bit address share a single bus word.

The block also produces one even-parity bit per byte lane. Parity is produced only while data is on the bus, never for an address. All outputs are registered once, so each result appears one clock after its inputs. Phase timing, chip-select decoding and card-socket strobes are handled by the sequencer that drives `addr_phase_i` and `mode_i`.

Top module: `mux_lane_steer`

## Requirements
- R1: In any multiplexed mode (codes 1 to 5) with `addr_phase_i` high, `bus_o` is {~be_i[3:0], addr_i[27:0]}: inverted byte enables in bits [31:28], address in bits [27:0]. The data input has no effect.
- R2: In direct mode (code 0), `bus_o` is {wdata_i[7:0], addr_i[23:0]} whatever the phase.
- R3: In 8-bit mode (code 1) during the data phase, wdata_i[7:0] is driven on bits [31:24].
- R4: During the data phase, 16-bit big-endian mode (code 2) puts wdata_i[15:8] on [31:24] and wdata_i[7:0] on [23:16]. 16-bit little-endian mode (code 3) swaps these two bytes.
- R5: During the data phase, 32-bit big-endian mode (code 4) drives wdata_i unchanged. 32-bit little-endian mode (code 5) reverses its byte order, so wdata_i[7:0] lands on [31:24] and wdata_i[31:24] lands on [7:0].
- R6: par_o[k] is the XOR of bus lane k (bits [8k+7:8k]), so that each lane plus its bit has even parity. This holds for every lane in the data phase of modes 1 to 5, and for lane 3 alone in direct mode. par_o is zero in the address phase of modes 1 to 5.
- R7: In the 8-bit and 16-bit data phases, the lanes that carry no data are driven to zero.
- R8: `rdata_o` re-assembles `bus_rd_i` as the inverse of the write mapping of the current mode and is zero above the mode's width. Direct mode and 8-bit mode read lane [31:24] into bits [7:0].
- R9: Mode codes 6 and 7 are reserved and give zero on `bus_o`, `par_o` and `rdata_o`.
- R10: Every output is registered. It follows its inputs one clock later and is zero while `rst_ni` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_phase_i | input | 1 | High during the address-latch phase |
| mode_i | input | 3 | Lane mode code (0 direct, 1 8-bit, 2/3 16-bit BE/LE, 4/5 32-bit BE/LE) |
| addr_i | input | 28 | Device address |
| be_i | input | 4 | Byte enables, active high |
| wdata_i | input | 32 | Write data, right-justified |
| bus_rd_i | input | 32 | Value sampled from the shared bus on reads |
| bus_o | output | 32 | Value to drive onto the shared bus |
| par_o | output | 4 | Per-lane even parity |
| rdata_o | output | 32 | Read data, right-justified |

## Verification
The assertions compare each output with the inputs of the previous clock. They therefore assume that the inputs are stable around each rising edge and that the reset has released before the first comparison. The bench changes inputs only on falling edges and checks each result on the next falling edge, after the single register stage. The stimulus covers all eight mode codes in both phases, with patterns that set every byte and every byte-enable bit to a different value. It also includes the reserved codes, so that any misrouted lane or dropped byte enable appears at the ports.

// File: rtl/lane_pkg.sv
package lane_pkg;
  typedef enum logic [2:0] {
    MODE_DIRECT = 3'd0,
    MODE_W8     = 3'd1,
    MODE_W16_BE = 3'd2,
    MODE_W16_LE = 3'd3,
    MODE_W32_BE = 3'd4,
    MODE_W32_LE = 3'd5
  } lane_mode_e;

  // bytes carried in data phase; 0 for direct and reserved codes
  function automatic int mode_bytes(logic [2:0] m);
    case (m)
      MODE_W8:                  return 1;
      MODE_W16_BE, MODE_W16_LE: return 2;
      MODE_W32_BE, MODE_W32_LE: return 4;
      default:                  return 0;
    endcase
  endfunction

  function automatic logic mode_le(logic [2:0] m);
    return (m == MODE_W16_LE) || (m == MODE_W32_LE);
  endfunction
endpackage

// File: rtl/lane_wr_map.sv
module lane_wr_map import lane_pkg::*; #(
  parameter int LANES  = 4,
  parameter int BYTE_W = 8,
  localparam int DATA_W = LANES * BYTE_W,
  localparam int ADDR_W = DATA_W - LANES
) (
  input  logic [2:0]        mode_i,
  input  logic              addr_phase_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LANES-1:0]  be_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] bus_o,
  output logic [LANES-1:0]  lane_en_o
);
  int nbytes;
  logic le;

  always_comb begin
    nbytes    = mode_bytes(mode_i);
    le        = mode_le(mode_i);
    bus_o     = '0;
    lane_en_o = '0;
    if (mode_i == MODE_DIRECT) begin
      bus_o = {wdata_i[BYTE_W-1:0], addr_i[DATA_W-BYTE_W-1:0]};
      lane_en_o[LANES-1] = 1'b1;
    end else if (nbytes != 0) begin
      if (addr_phase_i) begin
        bus_o = {~be_i, addr_i};
      end else begin
        lane_en_o = '1;
        // byte j of the device word sits on lane LANES-1-j (LE) or mirrored within width (BE)
        for (int j = 0; j < LANES; j++) begin
          if (j < nbytes) begin
            bus_o[(LANES-1-j)*BYTE_W +: BYTE_W] =
              le ? wdata_i[j*BYTE_W +: BYTE_W] : wdata_i[(nbytes-1-j)*BYTE_W +: BYTE_W];
          end
        end
      end
    end
  end
endmodule

// File: rtl/lane_parity.sv
module lane_parity #(
  parameter int LANES  = 4,
  parameter int BYTE_W = 8,
  localparam int DATA_W = LANES * BYTE_W
) (
  input  logic [DATA_W-1:0] bus_i,
  input  logic [LANES-1:0]  lane_en_i,
  output logic [LANES-1:0]  par_o
);
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign par_o[k] = lane_en_i[k] & (^bus_i[k*BYTE_W +: BYTE_W]);
  end
endmodule

// File: rtl/lane_rd_map.sv
module lane_rd_map import lane_pkg::*; #(
  parameter int LANES  = 4,
  parameter int BYTE_W = 8,
  localparam int DATA_W = LANES * BYTE_W
) (
  input  logic [2:0]        mode_i,
  input  logic [DATA_W-1:0] bus_rd_i,
  output logic [DATA_W-1:0] rdata_o
);
  int nbytes;
  logic le;

  always_comb begin
    nbytes  = mode_bytes(mode_i);
    le      = mode_le(mode_i);
    rdata_o = '0;
    if (mode_i == MODE_DIRECT) begin
      rdata_o[BYTE_W-1:0] = bus_rd_i[DATA_W-1 -: BYTE_W];
    end else begin
      for (int j = 0; j < LANES; j++) begin
        if (j < nbytes) begin
          rdata_o[j*BYTE_W +: BYTE_W] =
            le ? bus_rd_i[(LANES-1-j)*BYTE_W +: BYTE_W]
               : bus_rd_i[(LANES-nbytes+j)*BYTE_W +: BYTE_W];
        end
      end
    end
  end
endmodule

// File: rtl/mux_lane_steer.sv
module mux_lane_steer #(
  parameter int LANES  = 4,
  parameter int BYTE_W = 8,
  localparam int DATA_W = LANES * BYTE_W,
  localparam int ADDR_W = DATA_W - LANES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              addr_phase_i,
  input  logic [2:0]        mode_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LANES-1:0]  be_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] bus_rd_i,
  output logic [DATA_W-1:0] bus_o,
  output logic [LANES-1:0]  par_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] bus_d, rdata_d;
  logic [LANES-1:0]  lane_en, par_d;

  lane_wr_map #(.LANES(LANES), .BYTE_W(BYTE_W)) u_wr (
    .mode_i      (mode_i),
    .addr_phase_i(addr_phase_i),
    .addr_i      (addr_i),
    .be_i        (be_i),
    .wdata_i     (wdata_i),
    .bus_o       (bus_d),
    .lane_en_o   (lane_en)
  );

  lane_parity #(.LANES(LANES), .BYTE_W(BYTE_W)) u_par (
    .bus_i    (bus_d),
    .lane_en_i(lane_en),
    .par_o    (par_d)
  );

  lane_rd_map #(.LANES(LANES), .BYTE_W(BYTE_W)) u_rd (
    .mode_i  (mode_i),
    .bus_rd_i(bus_rd_i),
    .rdata_o (rdata_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bus_o   <= '0;
      par_o   <= '0;
      rdata_o <= '0;
    end else begin
      bus_o   <= bus_d;
      par_o   <= par_d;
      rdata_o <= rdata_d;
    end
  end
endmodule

// File: rtl/mux_lane_steer_chk.sv
module mux_lane_steer_chk #(
  parameter int LANES  = 4,
  parameter int BYTE_W = 8,
  localparam int DATA_W = LANES * BYTE_W,
  localparam int ADDR_W = DATA_W - LANES
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              addr_phase_i,
  input logic [2:0]        mode_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [LANES-1:0]  be_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [DATA_W-1:0] bus_o,
  input logic [LANES-1:0]  par_o,
  input logic [DATA_W-1:0] rdata_o
);
  logic past_ok;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  assert_addr_pack_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(addr_phase_i) && $past(mode_i) >= 3'd1 && $past(mode_i) <= 3'd5
    |-> bus_o == {~$past(be_i), $past(addr_i)});

  assert_addr_nopar_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(addr_phase_i) && $past(mode_i) >= 3'd1 && $past(mode_i) <= 3'd5
    |-> par_o == '0);

  for (genvar k = 0; k < LANES; k++) begin : g_par
    assert_lane_even_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      past_ok && !$past(addr_phase_i) && $past(mode_i) >= 3'd1 && $past(mode_i) <= 3'd5
      |-> par_o[k] == ^bus_o[k*BYTE_W +: BYTE_W]);
  end

  assert_direct_map_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(mode_i) == 3'd0
    |-> bus_o == {$past(wdata_i[BYTE_W-1:0]), $past(addr_i[DATA_W-BYTE_W-1:0])});

  assert_w8_idle_lanes_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && !$past(addr_phase_i) && $past(mode_i) == 3'd1
    |-> bus_o[DATA_W-BYTE_W-1:0] == '0);

  assert_w8_rd_narrow_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(mode_i) == 3'd1 |-> rdata_o[DATA_W-1:BYTE_W] == '0);

  assert_rsvd_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(mode_i) > 3'd5
    |-> bus_o == '0 && par_o == '0 && rdata_o == '0);
endmodule

bind mux_lane_steer mux_lane_steer_chk #(.LANES(LANES), .BYTE_W(BYTE_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .addr_phase_i(addr_phase_i),
  .mode_i      (mode_i),
  .addr_i      (addr_i),
  .be_i        (be_i),
  .wdata_i     (wdata_i),
  .bus_o       (bus_o),
  .par_o       (par_o),
  .rdata_o     (rdata_o)
);

// File: tb/sim_mux_lane_steer.sv
`timescale 1ns/1ps
module sim_mux_lane_steer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ph = 1'b0;
  logic [2:0]  mode = 3'd0;
  logic [27:0] addr = '0;
  logic [3:0]  be = '0;
  logic [31:0] wd = '0, rd = '0;
  logic [31:0] bus, rdat;
  logic [3:0]  par;
  int checks = 0, errors = 0;

  typedef struct { logic [31:0] bus; logic [3:0] par; logic [31:0] rd; string tag; } exp_t;
  exp_t q[$];

  always #4 clk = ~clk;

  mux_lane_steer u0 (
    .clk_i(clk), .rst_ni(rst_n), .addr_phase_i(ph), .mode_i(mode), .addr_i(addr),
    .be_i(be), .wdata_i(wd), .bus_rd_i(rd), .bus_o(bus), .par_o(par), .rdata_o(rdat)
  );

  function automatic logic [31:0] ref_bus(logic [2:0] m, logic p, logic [27:0] a,
                                          logic [3:0] b, logic [31:0] d);
    if (m == 3'd0) return {d[7:0], a[23:0]};
    if (m > 3'd5) return 32'h0;
    if (p) return {~b, a};
    case (m)
      3'd1: return {d[7:0], 24'h0};
      3'd2: return {d[15:8], d[7:0], 16'h0};
      3'd3: return {d[7:0], d[15:8], 16'h0};
      3'd4: return d;
      default: return {d[7:0], d[15:8], d[23:16], d[31:24]};
    endcase
  endfunction

  function automatic logic [3:0] ref_par(logic [2:0] m, logic p, logic [31:0] b);
    if (m == 3'd0) return {^b[31:24], 3'b000};
    if (m > 3'd5 || p) return 4'h0;
    return {^b[31:24], ^b[23:16], ^b[15:8], ^b[7:0]};
  endfunction

  function automatic logic [31:0] ref_rd(logic [2:0] m, logic [31:0] r);
    case (m)
      3'd0, 3'd1: return {24'h0, r[31:24]};
      3'd2: return {16'h0, r[31:16]};
      3'd3: return {16'h0, r[23:16], r[31:24]};
      3'd4: return r;
      3'd5: return {r[7:0], r[15:8], r[23:16], r[31:24]};
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tag_of(logic [2:0] m, logic p);
    if (m > 3'd5) return "R9";
    if (m == 3'd0) return "R2";
    if (p) return "R1";
    case (m)
      3'd1: return "R3 R7";
      3'd2, 3'd3: return "R4 R7";
      default: return "R5";
    endcase
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // called at a falling edge: apply inputs, wait one register stage, compare
  task automatic step(logic [2:0] m, logic p, logic [27:0] a, logic [3:0] b,
                      logic [31:0] d, logic [31:0] r);
    exp_t e;
    mode = m; ph = p; addr = a; be = b; wd = d; rd = r;
    e.bus = ref_bus(m, p, a, b, d);
    e.par = ref_par(m, p, e.bus);
    e.rd  = ref_rd(m, r);
    e.tag = tag_of(m, p);
    q.push_back(e);
    @(posedge clk);
    @(negedge clk);
    e = q.pop_front();
    check({e.tag, " R10 bus"}, bus, e.bus);
    check("R6 parity", {28'h0, par}, {28'h0, e.par});
    check("R8 rdata", rdat, e.rd);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wd = 32'hDEAD_BEEF; addr = 28'hABC_DEF1; mode = 3'd4;
    repeat (3) @(negedge clk);
    check("R10 reset bus", bus, 32'h0);
    check("R10 reset par", {28'h0, par}, 32'h0);
    check("R10 reset rdata", rdat, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int m = 0; m < 8; m++) begin
      step(3'(m), 1'b1, 28'h89A_BCDE, 4'b0101, 32'h1122_3344, 32'hA1B2_C3D4);
      step(3'(m), 1'b0, 28'h89A_BCDE, 4'b0101, 32'h1122_3344, 32'hA1B2_C3D4);
      step(3'(m), 1'b1, 28'hFFF_FFFF, 4'b1110, 32'h0180_7F01, 32'h8001_FE7F);
      step(3'(m), 1'b0, 28'h000_0000, 4'b0000, 32'h0180_7F01, 32'h8001_FE7F);
      step(3'(m), 1'b0, 28'h123_4567, 4'b1111, 32'hFFFF_FFFF, 32'h0000_0000);
    end
    for (int i = 0; i < 600; i++) begin
      step(3'($urandom_range(0, 7)), 1'($urandom), 28'($urandom), 4'($urandom),
           $urandom, $urandom);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule